// File: doc/BRIEF.md
# Multicast Group Address Hash Filter

This block sits on the receive path and decides whether a frame carrying a group (multicast) destination address should be kept. Destination address bytes arrive one per cycle, in wire order, on a byte stream qualified by a valid strobe. A start-of-frame pulse marks each new frame. The block folds the six address bytes into a reflected CRC-32 and reverses the bit order of the finished value. The top eight bits of the reversed value then index a 256-entry table of single-bit flags. The flag at that index is the verdict.

The table is held as eight 32-bit words. Within a word, entries are numbered from the most significant bit downward. Software maintains the table through a word-wide port. Each access can replace a word, OR a mask into it, or clear the bits of a mask, so a single group can be joined or left without touching the other entries. Any word can be read back at any time.

A frame whose first address byte has bit 0 clear is an individual address. For such a frame the table is not consulted, and a separate pass-through pulse is raised instead of a verdict.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC register is loaded with all ones and consumes exactly the first six valid bytes of a frame, in arrival order. For each byte, the byte is XORed into bits 7:0 and the register then shifts right eight times, XORing 0xEDB88320 after every shift that drops out a 1.
- R2: Once the sixth byte is absorbed, the 32-bit CRC is bit-reversed (bit i moves to bit 31−i). Bits 31:24 of the reversed value form the 8-bit hash index, which appears on `hash_idx_o` together with the decision pulse and holds its value until the next decision.
- R3: Index bits 7:5 select table word 0..7. Index bits 4:0 give a position p within that word, and p corresponds to word bit 31−p. `grp_accept_o` equals that table bit.
- R4: After reset, all eight table words read zero, no pulse outputs are asserted and `hash_idx_o` is zero, so a group frame is rejected.
- R5: A table access with `wr_en_i` high acts on word `wr_addr_i` according to `wr_mode_i`. Mode 0 replaces the word with `wr_data_i`. Mode 1 sets the bits that are 1 in `wr_data_i`. Mode 2 clears the bits that are 1 in `wr_data_i`. Mode 3 leaves the table unchanged. In every mode the other words are left unchanged. `rd_data_o` shows word `rd_addr_i` combinationally.
- R6: When bit 0 of the first address byte is 1, the frame receives a verdict on `grp_dec_vld_o`. When that bit is 0, only `ucast_pass_o` pulses. The two never assert together.
- R7: The decision pulse lasts exactly one cycle and arrives in the cycle after the sixth valid byte is presented. Valid bytes that arrive after the sixth byte are ignored until the next start-of-frame.
- R8: `sof_i` restarts address collection and re-presets the CRC. If `byte_vld_i` is high in the same cycle, that byte is the first address byte of the new frame. A frame cut short by `sof_i` produces no pulse.
- R9: Cycles with `byte_vld_i` low neither advance nor disturb the address collection.
- R10: The lookup for a decision uses the table contents as they were before any table access made in the same cycle as the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_vld_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Destination address byte, wire order |
| wr_en_i | input | 1 | Table access strobe |
| wr_mode_i | input | 2 | 0 replace, 1 set mask, 2 clear mask, 3 no operation |
| wr_addr_i | input | 3 | Table word selected for access |
| wr_data_i | input | 32 | Word value or bit mask |
| rd_addr_i | input | 3 | Table word to read |
| rd_data_o | output | 32 | Table word contents |
| grp_dec_vld_o | output | 1 | Verdict pulse for a group address |
| grp_accept_o | output | 1 | Verdict: 1 accept, 0 reject |
| ucast_pass_o | output | 1 | Pulse for an individual address (no verdict) |
| hash_idx_o | output | 8 | Hash index of the latest decision |

## Verification
The bench builds the block with its default parameters: six address bytes, eight 32-bit words and the standard polynomial. With these values every one of the 256 indices, and every word and bit position, can be reached by random addresses. The reference model computes the hash a different way, with a forward MSB-first CRC using the non-reflected polynomial fed each byte LSB first, which yields the reversed value directly. Directed frames then cover:
- cut-short frames
- gaps in the byte stream
- extra bytes after the sixth
- a start-of-frame pulse that arrives together with a byte
- a table access in the same cycle as the sixth byte

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          NWORDS     = 8,
  parameter int          WORD_W     = 32,
  parameter logic [31:0] POLY       = 32'hEDB88320
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sof_i,
  input  logic                              byte_vld_i,
  input  logic [7:0]                        byte_i,
  input  logic                              wr_en_i,
  input  logic [1:0]                        wr_mode_i,
  input  logic [$clog2(NWORDS)-1:0]         wr_addr_i,
  input  logic [WORD_W-1:0]                 wr_data_i,
  input  logic [$clog2(NWORDS)-1:0]         rd_addr_i,
  output logic [WORD_W-1:0]                 rd_data_o,
  output logic                              grp_dec_vld_o,
  output logic                              grp_accept_o,
  output logic                              ucast_pass_o,
  output logic [$clog2(NWORDS*WORD_W)-1:0]  hash_idx_o
);
  localparam int SEL_W = $clog2(NWORDS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = SEL_W + BIT_W;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(ADDR_BYTES);

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (r[0] ? POLY : 32'h0);
    return r;
  endfunction

  logic [NWORDS-1:0][WORD_W-1:0] tbl;
  logic [CNT_W-1:0] cnt, cnt_eff;
  logic [31:0]      crc, crc_eff, crc_nxt, crc_rev;
  logic             grp, grp_eff, take, last;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] wsel;
  logic [BIT_W-1:0] bsel;

  assign cnt_eff = sof_i ? '0 : cnt;
  assign crc_eff = sof_i ? '1 : crc;
  assign take    = byte_vld_i && (cnt_eff < DONE_CNT);
  assign last    = take && (cnt_eff == LAST_CNT);
  assign grp_eff = (cnt_eff == '0) ? byte_i[0] : grp;
  assign crc_nxt = crc_step(crc_eff, byte_i);

  always_comb
    for (int i = 0; i < 32; i++)
      crc_rev[31-i] = crc_nxt[i];

  assign idx  = crc_rev[31 -: IDX_W];
  assign wsel = idx[IDX_W-1 -: SEL_W];
  assign bsel = idx[BIT_W-1:0];
  assign rd_data_o = tbl[rd_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      crc           <= '1;
      grp           <= 1'b0;
      grp_dec_vld_o <= 1'b0;
      grp_accept_o  <= 1'b0;
      ucast_pass_o  <= 1'b0;
      hash_idx_o    <= '0;
    end else begin
      if (sof_i) begin
        cnt <= '0;
        crc <= '1;
      end
      if (take) begin
        cnt <= cnt_eff + 1'b1;
        crc <= crc_nxt;
        grp <= grp_eff;
      end
      grp_dec_vld_o <= last && grp_eff;
      ucast_pass_o  <= last && !grp_eff;
      grp_accept_o  <= last && grp_eff && tbl[wsel][BIT_W'(WORD_W-1) - bsel];
      if (last) hash_idx_o <= idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl <= '0;
    else if (wr_en_i) begin
      case (wr_mode_i)
        2'd0:    tbl[wr_addr_i] <= wr_data_i;
        2'd1:    tbl[wr_addr_i] <= tbl[wr_addr_i] | wr_data_i;
        2'd2:    tbl[wr_addr_i] <= tbl[wr_addr_i] & ~wr_data_i;
        default: ;
      endcase
    end
  end

  // R6
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grp_dec_vld_o, ucast_pass_o}));

  // R7
  dec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_dec_vld_o || ucast_pass_o) |-> $past(byte_vld_i));

  // R7
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_dec_vld_o || ucast_pass_o) |=> !(grp_dec_vld_o || ucast_pass_o));

  // R5
  set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_mode_i == 2'd1) |=>
      ((tbl[$past(wr_addr_i)] & $past(wr_data_i)) == $past(wr_data_i)));

  // R5
  clr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_mode_i == 2'd2) |=> ((tbl[$past(wr_addr_i)] & $past(wr_data_i)) == '0));

  // R5
  nop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || wr_mode_i == 2'd3) |=> $stable(tbl));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_dec_vld_o || ucast_pass_o) |-> $stable(hash_idx_o));
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        sof = 0, vld = 0, we = 0;
  logic [7:0]  bt = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  wa = 0, ra = 0;
  logic [31:0] wd = 0, rd;
  logic        dv, acc, uc;
  logic [7:0]  hidx;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_tbl [8];
  int          m_cnt;
  logic [31:0] m_crc;
  logic        m_grp;
  logic [7:0]  e_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(bt),
    .wr_en_i(we), .wr_mode_i(mode), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .grp_dec_vld_o(dv), .grp_accept_o(acc),
    .ucast_pass_o(uc), .hash_idx_o(hidx)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Forward CRC, polynomial 0x04C11DB7, bytes fed LSB first: gives the reversed value directly.
  function automatic logic [31:0] fwd(input logic [31:0] r, input logic [7:0] b);
    logic [31:0] x = r;
    for (int k = 0; k < 8; k++) begin
      logic fb = x[31] ^ b[k];
      x = x << 1;
      if (fb) x = x ^ 32'h04C11DB7;
    end
    return x;
  endfunction

  function automatic logic [7:0] hash_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) r = fwd(r, a[47-8*i -: 8]);
    return r[31:24];
  endfunction

  task automatic step(input logic s, input logic v, input logic [7:0] b,
                      input logic w, input logic [1:0] md, input logic [2:0] a,
                      input logic [31:0] d, input logic [2:0] r);
    int c; logic [31:0] cr; logic g; logic e_dv, e_uc, e_acc;
    @(negedge clk);
    sof = s; vld = v; bt = b; we = w; mode = md; wa = a; wd = d; ra = r;
    c = s ? 0 : m_cnt; cr = s ? 32'hFFFFFFFF : m_crc; g = m_grp;
    e_dv = 0; e_uc = 0; e_acc = 0;
    if (v && c < 6) begin
      if (c == 0) g = b[0];
      cr = fwd(cr, b);
      c++;
      if (c == 6) begin
        e_idx = cr[31:24];
        if (g) begin
          e_dv = 1;
          e_acc = m_tbl[e_idx[7:5]][31 - e_idx[4:0]];
        end else e_uc = 1;
      end
    end
    m_cnt = c; m_crc = cr; m_grp = g;
    if (w) case (md)
      2'd0: m_tbl[a] = d;
      2'd1: m_tbl[a] = m_tbl[a] | d;
      2'd2: m_tbl[a] = m_tbl[a] & ~d;
      default: ;
    endcase
    @(posedge clk); #1;
    check(dv == e_dv, "R6 R7 R8 R9 group pulse", {31'b0, dv}, {31'b0, e_dv});
    check(uc == e_uc, "R6 R7 unicast pulse", {31'b0, uc}, {31'b0, e_uc});
    check(acc == e_acc, "R3 R10 verdict", {31'b0, acc}, {31'b0, e_acc});
    check(hidx == e_idx, "R1 R2 hash index", {24'b0, hidx}, {24'b0, e_idx});
    check(rd == m_tbl[r], "R5 table read", rd, m_tbl[r]);
  endtask

  task automatic idle(input logic [2:0] r);
    step(0, 0, 0, 0, 0, 0, 0, r);
  endtask

  task automatic frame(input logic [47:0] a);
    for (int i = 0; i < 6; i++) step(i == 0, 1, a[47-8*i -: 8], 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] h;
    logic [47:0] ga;
    for (int i = 0; i < 8; i++) m_tbl[i] = 0;
    m_cnt = 0; m_crc = 32'hFFFFFFFF; m_grp = 0; e_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    // R4 reset state
    check(!dv && !uc && !acc && hidx == 0, "R4 reset outputs", {29'b0, dv, uc, acc}, 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) idle(3'(i));            // R4 table zero
    ga = 48'h01005E0000FB;
    frame(ga);                                           // R4 group rejected on empty table
    h = hash_of(ga);
    step(0, 0, 0, 1, 2'd1, h[7:5], 32'h1 << (31 - h[4:0]), h[7:5]);   // R5 set
    frame(ga); idle(h[7:5]);                             // R3 accepted
    check(acc == 0, "R7 verdict single cycle", {31'b0, acc}, 0);
    step(0, 0, 0, 1, 2'd3, h[7:5], 32'hFFFFFFFF, h[7:5]);             // R5 mode 3 no-op
    step(0, 0, 0, 1, 2'd2, h[7:5], 32'h1 << (31 - h[4:0]), h[7:5]);   // R5 clear
    frame(ga);                                           // rejected again
    step(0, 0, 0, 1, 2'd0, 3'd0, 32'h80000001, 3'd0);    // R5 replace
    frame(48'h001122334455);                             // R6 unicast
    // R9 gaps, R7 extra bytes
    for (int i = 0; i < 6; i++) begin step(i == 0, 1, 8'h33 + 8'(i), 0, 0, 0, 0, 0); idle(0); end
    for (int i = 0; i < 4; i++) step(0, 1, 8'hA5, 0, 0, 0, 0, 0);
    // R8 cut-short frame then sof with byte
    for (int i = 0; i < 4; i++) step(i == 0, 1, 8'hFF, 0, 0, 0, 0, 0);
    frame(48'hFFFFFFFFFFFF);
    // R10 write in same cycle as sixth byte
    ga = 48'h333300000001; h = hash_of(ga);
    for (int i = 0; i < 5; i++) step(i == 0, 1, ga[47-8*i -: 8], 0, 0, 0, 0, 0);
    step(0, 1, ga[7:0], 1, 2'd0, h[7:5], 32'hFFFFFFFF, h[7:5]);
    frame(ga);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] rr = $urandom;
      step(rr[3:0] == 0, rr[6:4] != 0, 8'($urandom), rr[11:8] == 0, rr[13:12],
           rr[16:14], $urandom, rr[19:17]);
    end
    finish_run();
  end
endmodule